// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block scans a switch matrix of up to five drive columns and six sense rows. In hardware mode it pulls one column low per scan tick and watches the rows. The row inputs idle high through external pull-ups, and a low row means the switch at that crossing is closed. A closed switch is reported only after the same row and column pair has read low for a programmable number of consecutive tick-paced samples. The report is a latched row and column code with a valid flag. After a report, no further key is reported until a whole column sweep sees the matrix fully released.

Software reaches the block through a small register port with one-cycle write strobes and read strobes. The read data is combinational. With hardware scanning switched off, software writes the column drive value directly and reads the sampled rows back, so it can run its own scan. A size setting shrinks the active matrix. Columns outside the size are never pulled low, and rows outside the size never take part in detection.

Register map (8-bit data): address 0 control ([0] hardware scan enable, [7:4] debounce count N); address 1 size ([2:0] active columns, [6:4] active rows); address 2 column drive; address 3 sampled rows (read-only); address 4 key status ([7] valid, [6:4] row index, [2:0] column index).

Top module: `keypad_scanner`

## Requirements
- R1: After the synchronous active-high reset, all column outputs are high, hardware scanning is off, control reads 0x40, size reads 0x65 and status reads 0x00.
- R2: With hardware scanning on, at most one column output is low at any time. The low column advances only on a scan tick, every column inside the active size is visited, and columns at or above the active column count stay high.
- R3: With hardware scanning off, a write to address 2 drives the column outputs directly, with columns outside the active size forced high. A read of address 2 returns the current column output levels in both modes.
- R4: Address 3 returns the row levels captured at the latest scan tick (bit r = row r, 0 = low), with rows at or above the active row count reading 1.
- R5: A key is accepted once the same row reads low in the held column for N consecutive scan ticks. A missing or changed row before then restarts the count, and a debounce field of 0 acts as N = 1.
- R6: On acceptance, status bit 7 becomes 1 and bits [6:4] and [2:0] hold the accepted row and column indices.
- R7: A read of address 4 clears the valid bit in the following cycle, unless an acceptance happens in the same cycle.
- R8: After an acceptance, no new key is reported while any key stays closed. Scanning for a new key resumes only after a full column sweep in which no row reads low.
- R9: When several rows read low in the same column, the lowest-numbered row is reported.
- R10: A switch on a row or column outside the active size is never reported.
- R11: An active size field of 0 acts as 1, and a value above the matrix dimension acts as the dimension.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | One-cycle pulse, about 1 kHz, pacing scan and debounce |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status valid when at address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| col_out | output | NUM_COLS | Column drive lines, active low |
| row_in | input | NUM_ROWS | Row sense lines, low when a switch is closed |

## Verification
The bench builds the block with its default parameters: five columns, six rows and a four-bit debounce field. With these values every one of the 30 crossings can be pressed at random with debounce counts from 0 to 6. A bouncing switch is toggled every two ticks against N = 4 to show that the count restarts. The active size is shrunk to three columns by four rows, so switches outside it can be held down and shown to be both undriven and unreported, while a switch inside it still reports.

// File: rtl/kp_pkg.sv
package kp_pkg;
  // width of index and size fields; matrix dimensions must stay below 2**FW
  localparam int FW = 3;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_SIZE = 3'd1;
  localparam logic [2:0] A_COLV = 3'd2;
  localparam logic [2:0] A_ROWV = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  typedef enum logic [1:0] {
    ST_SEEK,   // sweeping columns, nothing pending
    ST_HOLD,   // column parked, counting consecutive low samples
    ST_DRAIN   // key reported, waiting for a clean sweep
  } scan_st_t;
endpackage

// File: rtl/kp_regs.sv
module kp_regs
  import kp_pkg::*;
#(
  parameter int NUM_COLS = 5,
  parameter int NUM_ROWS = 6,
  parameter int DB_W     = 4,
  parameter int DB_RESET = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [2:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [NUM_COLS-1:0] col_out,
  input  logic [NUM_ROWS-1:0] row_val,
  input  logic                accept,
  input  logic [FW-1:0]       acc_row,
  input  logic [FW-1:0]       acc_col,
  output logic                hw_en,
  output logic [DB_W-1:0]     eff_n,
  output logic [FW-1:0]       ncols_eff,
  output logic [FW-1:0]       nrows_eff,
  output logic [NUM_COLS-1:0] fw_cols,
  output logic                key_valid
);
  localparam logic [FW-1:0] MAXC = FW'(NUM_COLS);
  localparam logic [FW-1:0] MAXR = FW'(NUM_ROWS);

  logic [DB_W-1:0] dbn_q;
  logic [FW-1:0]   ncols_q, nrows_q, krow_q, kcol_q;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_en     <= 1'b0;
      dbn_q     <= DB_W'(DB_RESET);
      ncols_q   <= MAXC;
      nrows_q   <= MAXR;
      fw_cols   <= '1;
      key_valid <= 1'b0;
      krow_q    <= '0;
      kcol_q    <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: begin
            hw_en <= reg_wdata[0];
            dbn_q <= reg_wdata[4 +: DB_W];
          end
          A_SIZE: begin
            ncols_q <= reg_wdata[0 +: FW];
            nrows_q <= reg_wdata[4 +: FW];
          end
          A_COLV: if (!hw_en) fw_cols <= reg_wdata[NUM_COLS-1:0];
          default: ;
        endcase
      end
      if (accept) begin
        key_valid <= 1'b1;
        krow_q    <= acc_row;
        kcol_q    <= acc_col;
      end else if (reg_rd && reg_addr == A_STAT) begin
        key_valid <= 1'b0;
      end
    end
  end

  // clamp size fields into 1..dimension, debounce 0 -> 1
  always_comb begin
    if (ncols_q == '0)      ncols_eff = FW'(1);
    else if (ncols_q > MAXC) ncols_eff = MAXC;
    else                     ncols_eff = ncols_q;
    if (nrows_q == '0)      nrows_eff = FW'(1);
    else if (nrows_q > MAXR) nrows_eff = MAXR;
    else                     nrows_eff = nrows_q;
    eff_n = (dbn_q == '0) ? DB_W'(1) : dbn_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]         = hw_en;
        reg_rdata[4 +: DB_W] = dbn_q;
      end
      A_SIZE: begin
        reg_rdata[0 +: FW] = ncols_q;
        reg_rdata[4 +: FW] = nrows_q;
      end
      A_COLV: reg_rdata[NUM_COLS-1:0] = col_out;
      A_ROWV: reg_rdata[NUM_ROWS-1:0] = row_val;
      A_STAT: begin
        reg_rdata[7]       = key_valid;
        reg_rdata[4 +: FW] = krow_q;
        reg_rdata[0 +: FW] = kcol_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/kp_row_sync.sv
module kp_row_sync
  import kp_pkg::*;
#(
  parameter int NUM_ROWS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scan_tick,
  input  logic [NUM_ROWS-1:0] row_in,
  input  logic [FW-1:0]       nrows_eff,
  output logic [NUM_ROWS-1:0] row_low,
  output logic [NUM_ROWS-1:0] row_val
);
  logic [NUM_ROWS-1:0] meta_q, sync_q, in_size;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_mask
    assign in_size[r] = (FW'(r) < nrows_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q  <= '1;
      sync_q  <= '1;
      row_val <= '1;
    end else begin
      meta_q <= row_in;
      sync_q <= meta_q;
      if (scan_tick) row_val <= sync_q | ~in_size;
    end
  end

  assign row_low = ~sync_q & in_size;
endmodule

// File: rtl/kp_col_drive.sv
module kp_col_drive
  import kp_pkg::*;
#(
  parameter int NUM_COLS = 5
) (
  input  logic                hw_en,
  input  logic [FW-1:0]       col_idx,
  input  logic [FW-1:0]       ncols_eff,
  input  logic [NUM_COLS-1:0] fw_cols,
  output logic [NUM_COLS-1:0] col_out
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic in_size;
    assign in_size    = (FW'(c) < ncols_eff);
    assign col_out[c] = !in_size ? 1'b1
                      : hw_en    ? (col_idx != FW'(c))
                      :            fw_cols[c];
  end
endmodule

// File: rtl/kp_scan_fsm.sv
module kp_scan_fsm
  import kp_pkg::*;
#(
  parameter int NUM_ROWS = 6,
  parameter int DB_W     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scan_tick,
  input  logic                hw_en,
  input  logic [DB_W-1:0]     eff_n,
  input  logic [FW-1:0]       ncols_eff,
  input  logic [NUM_ROWS-1:0] row_low,
  output logic [FW-1:0]       col_idx,
  output logic                accept,
  output logic [FW-1:0]       acc_row,
  output logic [FW-1:0]       acc_col
);
  scan_st_t        st;
  logic [DB_W-1:0] cnt;
  logic [DB_W:0]   cnt_inc;
  logic [FW-1:0]   cand_row, low_row, nxt_col;
  logic            seen, any_low, last, same_row;

  always_comb begin
    low_row = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (row_low[r]) low_row = FW'(r);
    end
    any_low  = |row_low;
    same_row = any_low && (low_row == cand_row);
    last     = (col_idx >= ncols_eff - FW'(1));
    nxt_col  = last ? '0 : col_idx + FW'(1);
    cnt_inc  = {1'b0, cnt} + 1'b1;
    accept   = scan_tick && hw_en &&
               ((st == ST_SEEK && any_low && eff_n == DB_W'(1)) ||
                (st == ST_HOLD && same_row && cnt_inc >= {1'b0, eff_n}));
    acc_row  = low_row;
    acc_col  = col_idx;
  end

  always_ff @(posedge clk) begin
    if (rst || !hw_en) begin
      st       <= ST_SEEK;
      col_idx  <= '0;
      cnt      <= '0;
      cand_row <= '0;
      seen     <= 1'b0;
    end else if (scan_tick) begin
      case (st)
        ST_SEEK: begin
          if (any_low) begin
            cand_row <= low_row;
            cnt      <= DB_W'(1);
            if (accept) begin
              st      <= ST_DRAIN;
              seen    <= 1'b1;
              col_idx <= nxt_col;
            end else begin
              st <= ST_HOLD;
            end
          end else begin
            col_idx <= nxt_col;
          end
        end
        ST_HOLD: begin
          if (accept) begin
            st      <= ST_DRAIN;
            seen    <= 1'b1;
            col_idx <= nxt_col;
          end else if (same_row) begin
            cnt <= cnt_inc[DB_W-1:0];
          end else if (any_low) begin
            cand_row <= low_row;
            cnt      <= DB_W'(1);
          end else begin
            st      <= ST_SEEK;
            cnt     <= '0;
            col_idx <= nxt_col;
          end
        end
        default: begin
          col_idx <= nxt_col;
          if (last) begin
            seen <= 1'b0;
            if (!(seen || any_low)) st <= ST_SEEK;
          end else if (any_low) begin
            seen <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kp_pkg::*;
#(
  parameter int NUM_COLS = 5,
  parameter int NUM_ROWS = 6,
  parameter int DB_W     = 4,
  parameter int DB_RESET = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scan_tick,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [2:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic [NUM_COLS-1:0] col_out,
  input  logic [NUM_ROWS-1:0] row_in
);
  logic                hw_en, accept, key_valid;
  logic [DB_W-1:0]     eff_n;
  logic [FW-1:0]       ncols_eff, nrows_eff, col_idx, acc_row, acc_col;
  logic [NUM_COLS-1:0] fw_cols;
  logic [NUM_ROWS-1:0] row_low, row_val;

  kp_regs #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .DB_W(DB_W), .DB_RESET(DB_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .col_out(col_out), .row_val(row_val), .accept(accept),
    .acc_row(acc_row), .acc_col(acc_col), .hw_en(hw_en), .eff_n(eff_n),
    .ncols_eff(ncols_eff), .nrows_eff(nrows_eff), .fw_cols(fw_cols),
    .key_valid(key_valid)
  );

  kp_row_sync #(.NUM_ROWS(NUM_ROWS)) u_rows (
    .clk(clk), .rst(rst), .scan_tick(scan_tick), .row_in(row_in),
    .nrows_eff(nrows_eff), .row_low(row_low), .row_val(row_val)
  );

  kp_scan_fsm #(.NUM_ROWS(NUM_ROWS), .DB_W(DB_W)) u_fsm (
    .clk(clk), .rst(rst), .scan_tick(scan_tick), .hw_en(hw_en),
    .eff_n(eff_n), .ncols_eff(ncols_eff), .row_low(row_low),
    .col_idx(col_idx), .accept(accept), .acc_row(acc_row), .acc_col(acc_col)
  );

  kp_col_drive #(.NUM_COLS(NUM_COLS)) u_cols (
    .hw_en(hw_en), .col_idx(col_idx), .ncols_eff(ncols_eff),
    .fw_cols(fw_cols), .col_out(col_out)
  );
endmodule

// File: rtl/kp_checker.sv
module kp_checker
  import kp_pkg::*;
#(
  parameter int NUM_COLS = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                scan_tick,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [2:0]          reg_addr,
  input logic [NUM_COLS-1:0] col_out,
  input logic                hw_en,
  input logic [FW-1:0]       ncols_eff,
  input logic                accept,
  input logic                key_valid
);
  // R1
  rst_cols_high_chk: assert property (@(posedge clk)
    rst |=> (col_out == '1));

  // R2
  one_low_col_chk: assert property (@(posedge clk) disable iff (rst)
    hw_en |-> ($countones(~col_out) <= 1));

  // R2
  col_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_en && !scan_tick && !reg_wr) |=> $stable(col_out));

  // R2
  outside_size_high_chk: assert property (@(posedge clk) disable iff (rst)
    hw_en |-> (((~col_out) >> ncols_eff) == '0));

  // R7
  stat_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_STAT && !accept) |=> !key_valid);

  // R6
  valid_from_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(key_valid) |-> $past(accept));
endmodule

bind keypad_scanner kp_checker #(.NUM_COLS(NUM_COLS)) i_chk (
  .clk(clk), .rst(rst), .scan_tick(scan_tick), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .col_out(col_out), .hw_en(hw_en),
  .ncols_eff(ncols_eff), .accept(accept), .key_valid(key_valid)
);

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 5;
  localparam int NR = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scan_tick = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [NC-1:0] col_out;
  logic [NR-1:0] row_in;
  logic [NR*NC-1:0] keys = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_scanner i_keypad_scanner (
    .clk(clk), .rst(rst), .scan_tick(scan_tick), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .col_out(col_out), .row_in(row_in)
  );

  // switch matrix model: a closed switch pulls its row low while its column is low
  always_comb begin
    for (int r = 0; r < NR; r++) begin
      row_in[r] = 1'b1;
      for (int c = 0; c < NC; c++)
        if (keys[r*NC+c] && !col_out[c]) row_in[r] = 1'b0;
    end
  end

  initial begin
    forever begin
      repeat (5) @(negedge clk);
      scan_tick = 1'b1;
      @(negedge clk);
      scan_tick = 1'b0;
    end
  end

  function automatic logic [7:0] exp_stat(int r, int c);
    return 8'h80 | 8'(r << 4) | 8'(c);
  endfunction

  function automatic logic [NR*NC-1:0] key_bit(int r, int c);
    return (NR*NC)'(1) << (r*NC + c);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) @(posedge scan_tick);
    @(negedge clk);
  endtask

  task automatic hw_setup(int n, int nc, int nr);
    wr(3'd1, 8'((nr << 4) | nc));
    wr(3'd0, 8'((n << 4) | 1));
  endtask

  initial begin
    logic [7:0] d;
    logic [NC-1:0] seen_cols;
    bit one_low;
    bit high_ok;
    void'($urandom(77));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(col_out == 5'h1f, "R1", "columns after reset", col_out, 5'h1f);
    rd(3'd4, d); check(d == 8'h00, "R1", "status after reset", d, 0);
    rd(3'd0, d); check(d == 8'h40, "R1", "control after reset", d, 8'h40);
    rd(3'd1, d); check(d == 8'h65, "R1", "size after reset", d, 8'h65);

    // R3 firmware drive
    wr(3'd2, 8'h1b);
    check(col_out == 5'h1b, "R3", "firmware column drive", col_out, 5'h1b);
    rd(3'd2, d); check(d == 8'h1b, "R3", "column readback", d, 8'h1b);
    wr(3'd1, 8'h42);  // 2 columns: column 2 drive masked high
    check(col_out == 5'h1f, "R3", "drive outside size", col_out, 5'h1f);
    wr(3'd1, 8'h65);

    // R4 row sample, unused rows read 1
    keys = key_bit(3, 2) | key_bit(5, 2);
    ticks(2);
    rd(3'd3, d); check(d == 8'h17, "R4", "rows full size", d, 8'h17);
    wr(3'd1, 8'h45);
    ticks(2);
    rd(3'd3, d); check(d == 8'h37, "R4", "rows 4 active", d, 8'h37);
    keys = '0;
    wr(3'd1, 8'h65);

    // R2 hardware sweep
    hw_setup(2, 5, 6);
    seen_cols = '0; one_low = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if ($countones(~col_out) != 1) one_low = 1'b0;
      seen_cols |= ~col_out;
    end
    check(one_low, "R2", "exactly one column low", one_low, 1);
    check(seen_cols == 5'h1f, "R2", "all columns visited", seen_cols, 5'h1f);

    // R5 R6 R7 R8 random single keys
    for (int i = 0; i < 10; i++) begin
      int n, r, c;
      n = 1 + int'($urandom % 6);
      r = int'($urandom % NR);
      c = int'($urandom % NC);
      hw_setup(n, 5, 6);
      keys = key_bit(r, c);
      ticks(5 + n + 4);
      rd(3'd4, d); check(d == exp_stat(r, c), "R6", "random key code", d, exp_stat(r, c));
      rd(3'd4, d); check(d[7] == 1'b0, "R7", "valid cleared by read", d, 0);
      ticks(12);
      rd(3'd4, d); check(d[7] == 1'b0, "R8", "no repeat while held", d, 0);
      keys = '0;
      ticks(19);
    end

    // R5 debounce field 0 acts as 1
    hw_setup(0, 5, 6);
    keys = key_bit(0, 4);
    ticks(8);
    rd(3'd4, d); check(d == exp_stat(0, 4), "R5", "debounce zero", d, exp_stat(0, 4));
    keys = '0; ticks(19);

    // R5 bouncing switch never settles for 4 samples
    hw_setup(4, 5, 6);
    for (int i = 0; i < 24; i++) begin
      keys = keys ^ key_bit(2, 3);
      ticks(2);
    end
    keys = '0;
    rd(3'd4, d); check(d[7] == 1'b0, "R5", "bounce rejected", d, 0);
    ticks(19);

    // R8 new key reported after release
    hw_setup(2, 5, 6);
    keys = key_bit(1, 0);
    ticks(12);
    rd(3'd4, d); check(d == exp_stat(1, 0), "R8", "first key", d, exp_stat(1, 0));
    keys = '0; ticks(19);
    keys = key_bit(4, 3);
    ticks(12);
    rd(3'd4, d); check(d == exp_stat(4, 3), "R8", "key after release", d, exp_stat(4, 3));
    keys = '0; ticks(19);

    // R9 lowest row wins
    keys = key_bit(4, 1) | key_bit(1, 1) | key_bit(5, 1);
    ticks(12);
    rd(3'd4, d); check(d == exp_stat(1, 1), "R9", "lowest row", d, exp_stat(1, 1));
    keys = '0; ticks(19);

    // R10 R2 reduced size
    hw_setup(2, 3, 4);
    keys = key_bit(5, 0) | key_bit(2, 4);
    high_ok = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (col_out[4:3] != 2'b11) high_ok = 1'b0;
    end
    check(high_ok, "R2", "columns outside size high", high_ok, 1);
    ticks(20);
    rd(3'd4, d); check(d[7] == 1'b0, "R10", "outside keys ignored", d, 0);
    keys = keys | key_bit(3, 2);
    ticks(12);
    rd(3'd4, d); check(d == exp_stat(3, 2), "R10", "inside key reported", d, exp_stat(3, 2));
    keys = '0; ticks(19);

    // R11 size clamping
    hw_setup(2, 0, 7);
    seen_cols = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      seen_cols |= ~col_out;
    end
    check(seen_cols == 5'h01, "R11", "zero columns acts as one", seen_cols, 5'h01);
    keys = key_bit(5, 0);
    ticks(8);
    rd(3'd4, d); check(d == exp_stat(5, 0), "R11", "rows above max clamp", d, exp_stat(5, 0));

    // R1 reset while scanning with a key held
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check(col_out == 5'h1f, "R1", "columns during reset", col_out, 5'h1f);
    rst = 1'b0;
    rd(3'd4, d); check(d == 8'h00, "R1", "status after mid reset", d, 0);
    rd(3'd0, d); check(d == 8'h40, "R1", "control after mid reset", d, 8'h40);
    keys = '0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule